// File: doc/BRIEF.md
# Bus Target Termination Controller

This block sits behind the address decoder of a bus target. Once the target has claimed a cycle, it decides how that transaction ends. There are three outcomes. A completion moves one data word and ends the burst with a stop request. A retry refuses the cycle without moving data. A modem wait holds the cycle open while an external device gets ready.

The decoder presents a one-clock `claim` pulse with a 3-bit access kind. The block then drives the three active-low target response pins: device acknowledge, target data ready and stop. It drives them from the initiator's cycle-framing and initiator-ready pins.

Accesses to the external modem window wait for that device's ready strobe. The window is a fixed number of clocks, counted from the modem chip-select. CardBus mode forces a retry on every access to the card information structure.

The block carries no data path. The only transfer handshake is the bus's own pair: target data ready (`data_rdy_n`) and initiator ready (`init_rdy_n`). A data word moves on the rising edge at which both are low. While `init_rdy_n` is high, the initiator is applying back-pressure, and the target holds `data_rdy_n` low without dropping it. No other pin has flow control.

Top module: `tt_term_ctrl`

## Requirements
- R1: While `rst_n` is low, `dev_ack_n`, `data_rdy_n` and `term_n` are all high, and the block is idle.
- R2: A `claim` seen while idle with a kind of 0 (config space), 1 (control/status registers), 2 (flash buffer), 5, 6 or 7, or with kind 3 (card info) while `cardbus` is 0, drives all three outputs low on the next clock. This is a single-word disconnect.
- R3: A `claim` seen while idle with kind 3 and `cardbus` at 1 drives `dev_ack_n` and `term_n` low and keeps `data_rdy_n` high from the next clock. This is a retry, and no word moves.
- R4: On the clock where `data_rdy_n` and `init_rdy_n` are both low, one word moves. From the next clock `data_rdy_n` is high, so exactly one word moves per transaction.
- R5: While `data_rdy_n` is low and `init_rdy_n` is high, `data_rdy_n` stays low.
- R6: While `term_n` is low and no word is still pending, a clock at which `cyc_n` is high returns all three outputs high on the next clock.
- R7: A `claim` seen while idle with kind 4 (modem window) drives `dev_ack_n` low on the next clock and keeps `data_rdy_n` and `term_n` high. This is the modem wait.
- R8: In the modem wait, `mdm_rdy` high on any of the first 7 rising edges at which `mdm_sel_n` is low gives a single-word disconnect (all outputs low) on the next clock. This includes the 7th edge, where ready wins over the timeout.
- R9: If the 7th such edge arrives with `mdm_rdy` low, the cycle is retried: `term_n` goes low and `data_rdy_n` stays high on the next clock.
- R10: The 7-edge count is cleared on any edge where `mdm_sel_n` is high, and it restarts when the chip-select returns. While the chip-select is inactive the wait lasts indefinitely.
- R11: A `claim` seen while the block is not idle is ignored. The ongoing transaction ends exactly as it would have without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| claim | input | 1 | One-clock pulse from the decoder: this target owns the cycle |
| kind | input | 3 | Access kind: 0 config, 1 control/status, 2 flash, 3 card info, 4 modem, 5-7 handled as 1 |
| cardbus | input | 1 | CardBus mode flag |
| mdm_sel_n | input | 1 | Modem chip-select, active low |
| mdm_rdy | input | 1 | Modem ready strobe, active high |
| cyc_n | input | 1 | Initiator cycle framing, low while more data phases follow |
| init_rdy_n | input | 1 | Initiator ready, active low |
| dev_ack_n | output | 1 | Device acknowledge, active low |
| data_rdy_n | output | 1 | Target data ready, active low |
| term_n | output | 1 | Stop request, active low |

## Verification
Two functions can collide on one rising edge: the modem ready strobe and the expiry of the 7-edge window. The bench provokes this by raising `mdm_rdy` at exactly the 7th chip-select edge. It also runs one edge later, and once with a chip-select gap that restarts the count. Each case is judged by the word count the bus-functional initiator observes: one word when ready wins, none on the retry. A per-clock reference model checks the output pins on every clock.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam logic [2:0] K_CFG   = 3'd0;
  localparam logic [2:0] K_CSR   = 3'd1;
  localparam logic [2:0] K_FLASH = 3'd2;
  localparam logic [2:0] K_CIS   = 3'd3;
  localparam logic [2:0] K_MODEM = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_HALT  = 2'd2,
    ST_MWAIT = 2'd3
  } tt_state_e;

  // active-high view of the three target response pins
  typedef struct packed {
    logic ack;
    logic rdy;
    logic halt;
  } tt_drv_t;

endpackage

// File: rtl/tt_route.sv
module tt_route
  import tt_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       cardbus,
  output tt_state_e  entry
);

  always_comb begin
    unique case (kind)
      K_CIS:   entry = cardbus ? ST_HALT : ST_DATA;
      K_MODEM: entry = ST_MWAIT;
      default: entry = ST_DATA;
    endcase
  end

endmodule

// File: rtl/tt_wait_timer.sv
module tt_wait_timer #(
  parameter int WAIT_CLKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic expired
);

  localparam int CW = $clog2(WAIT_CLKS + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(WAIT_CLKS);
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CLKS - 1);

  logic [CW-1:0] cnt;

  // counts edges with the chip-select active, saturating at the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (sel_n)          cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // this edge is the last one of the window
  assign expired = !sel_n && (cnt >= CNT_LAST);

endmodule

// File: rtl/tt_seq.sv
module tt_seq
  import tt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      claim,
  input  tt_state_e entry,
  input  logic      cyc_n,
  input  logic      init_rdy_n,
  input  logic      sel_n,
  input  logic      mdm_rdy,
  input  logic      expired,
  output tt_drv_t   drv
);

  tt_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (claim) nxt = entry;
      ST_DATA:  if (!init_rdy_n) nxt = cyc_n ? ST_IDLE : ST_HALT;
      ST_HALT:  if (cyc_n) nxt = ST_IDLE;
      ST_MWAIT: if (!sel_n) begin
                  if (mdm_rdy)      nxt = ST_DATA;
                  else if (expired) nxt = ST_HALT;
                end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    drv.ack  = (st != ST_IDLE);
    drv.rdy  = (st == ST_DATA);
    drv.halt = (st == ST_DATA) || (st == ST_HALT);
  end

endmodule

// File: rtl/tt_term_ctrl.sv
module tt_term_ctrl
  import tt_pkg::*;
#(
  parameter int WAIT_CLKS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       claim,
  input  logic [2:0] kind,
  input  logic       cardbus,
  input  logic       mdm_sel_n,
  input  logic       mdm_rdy,
  input  logic       cyc_n,
  input  logic       init_rdy_n,
  output logic       dev_ack_n,
  output logic       data_rdy_n,
  output logic       term_n
);

  tt_state_e entry;
  logic      expired;
  tt_drv_t   drv;

  tt_route u_route (
    .kind    (kind),
    .cardbus (cardbus),
    .entry   (entry)
  );

  tt_wait_timer #(.WAIT_CLKS(WAIT_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (mdm_sel_n),
    .expired (expired)
  );

  tt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim      (claim),
    .entry      (entry),
    .cyc_n      (cyc_n),
    .init_rdy_n (init_rdy_n),
    .sel_n      (mdm_sel_n),
    .mdm_rdy    (mdm_rdy),
    .expired    (expired),
    .drv        (drv)
  );

  assign dev_ack_n  = !drv.ack;
  assign data_rdy_n = !drv.rdy;
  assign term_n     = !drv.halt;

endmodule

// File: rtl/tt_term_ctrl_chk.sv
module tt_term_ctrl_chk
  import tt_pkg::*;
#(
  parameter int WAIT_CLKS = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       claim,
  input logic [2:0] kind,
  input logic       cardbus,
  input logic       mdm_sel_n,
  input logic       mdm_rdy,
  input logic       cyc_n,
  input logic       init_rdy_n,
  input logic       dev_ack_n,
  input logic       data_rdy_n,
  input logic       term_n
);

  localparam int CW = $clog2(WAIT_CLKS + 1);

  logic [CW-1:0] seen;
  logic idle, waiting, plain_kind;

  assign idle       = dev_ack_n;
  assign waiting    = !dev_ack_n && data_rdy_n && term_n;
  assign plain_kind = (kind != K_MODEM) && !((kind == K_CIS) && cardbus);

  // independent tally of chip-select edges seen before the current one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen <= '0;
    else if (mdm_sel_n)              seen <= '0;
    else if (seen != CW'(WAIT_CLKS)) seen <= seen + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (dev_ack_n && data_rdy_n && term_n);
    end
  end

  p_disconnect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim && idle && plain_kind |=> !dev_ack_n && !data_rdy_n && !term_n);

  p_stop_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !term_n || !data_rdy_n |-> !dev_ack_n);

  p_cis_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim && idle && (kind == K_CIS) && cardbus |=> !dev_ack_n && !term_n && data_rdy_n);

  p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy_n && !init_rdy_n |=> data_rdy_n);

  p_hold_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy_n && init_rdy_n |=> !data_rdy_n);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !term_n && cyc_n && (data_rdy_n || !init_rdy_n) |=> dev_ack_n && term_n && data_rdy_n);

  p_modem_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim && idle && (kind == K_MODEM) |=> waiting);

  p_ready_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !mdm_sel_n && mdm_rdy |=> !data_rdy_n && !term_n);

  p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !mdm_sel_n && !mdm_rdy && (seen >= CW'(WAIT_CLKS - 1)) |=> !term_n && data_rdy_n);

  p_idle_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && mdm_sel_n |=> waiting);

endmodule

bind tt_term_ctrl tt_term_ctrl_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .claim      (claim),
  .kind       (kind),
  .cardbus    (cardbus),
  .mdm_sel_n  (mdm_sel_n),
  .mdm_rdy    (mdm_rdy),
  .cyc_n      (cyc_n),
  .init_rdy_n (init_rdy_n),
  .dev_ack_n  (dev_ack_n),
  .data_rdy_n (data_rdy_n),
  .term_n     (term_n)
);

// File: tb/tb_tt_term_ctrl.sv
`timescale 1ns/1ps
module tb_tt_term_ctrl;

  localparam int WAIT = 7;

  logic clk = 1'b0;
  logic rst_n, claim, cardbus, mdm_sel_n, mdm_rdy, cyc_n, init_rdy_n;
  logic [2:0] kind;
  logic dev_ack_n, data_rdy_n, term_n;

  int checks = 0;
  int errors = 0;
  int words  = 0;
  int cycles = 0;

  // reference model state
  int    m_mode = 0;   // 0 idle, 1 data offered, 2 stop held, 3 modem wait
  int    m_run  = 0;   // chip-select edges counted so far
  int    m_next;
  string m_tag  = "R1";
  logic [2:0] exp_pins;

  always #10 clk = ~clk;

  tt_term_ctrl dut (
    .clk(clk), .rst_n(rst_n), .claim(claim), .kind(kind), .cardbus(cardbus),
    .mdm_sel_n(mdm_sel_n), .mdm_rdy(mdm_rdy), .cyc_n(cyc_n), .init_rdy_n(init_rdy_n),
    .dev_ack_n(dev_ack_n), .data_rdy_n(data_rdy_n), .term_n(term_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // model step, then compare the pins a quarter period after the edge
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_tag = "R1";
    end else begin
      m_next = m_mode;
      if (claim && m_mode != 0) m_tag = "R11";
      case (m_mode)
        0: if (claim) begin
             if (kind == 3'd3 && cardbus) begin m_next = 2; m_tag = "R3"; end
             else if (kind == 3'd4)       begin m_next = 3; m_tag = "R7"; end
             else                         begin m_next = 1; m_tag = "R2"; end
           end
        1: if (!init_rdy_n) begin m_next = cyc_n ? 0 : 2; m_tag = "R4"; end
           else m_tag = "R5";
        2: if (cyc_n) begin m_next = 0; m_tag = "R6"; end
        3: if (!mdm_sel_n) begin
             if (mdm_rdy)              begin m_next = 1; m_tag = "R8"; end
             else if (m_run + 1 >= WAIT) begin m_next = 2; m_tag = "R9"; end
             else m_tag = "R10";
           end else m_tag = "R10";
        default: m_next = 0;
      endcase
      m_run  = mdm_sel_n ? 0 : ((m_run < WAIT) ? m_run + 1 : WAIT);
      m_mode = m_next;
    end
    #5;
    case (m_mode)
      0:       exp_pins = 3'b111;
      1:       exp_pins = 3'b000;
      2:       exp_pins = 3'b010;
      default: exp_pins = 3'b011;
    endcase
    check({dev_ack_n, data_rdy_n, term_n} == exp_pins, m_tag, "pins {ack,rdy,stop}",
          int'({dev_ack_n, data_rdy_n, term_n}), int'(exp_pins));
  end

  // word counter: both ready pins low between negedge and the next edge
  always @(posedge clk) begin
    #15;
    if (rst_n && !data_rdy_n && !init_rdy_n) words++;
  end

  task automatic run_access(input logic [2:0] k, input logic cb, input int irdy_wait,
                            input int stop_lag, input int exp_words, input string req,
                            input bit extra_claim);
    words = 0;
    @(negedge clk);
    claim = 1'b1; kind = k; cardbus = cb; cyc_n = 1'b0; init_rdy_n = 1'b1;
    @(negedge clk);
    claim = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i > 0 && dev_ack_n) break;
      if (i >= irdy_wait) init_rdy_n = 1'b0;
      if (i >= stop_lag && !term_n) cyc_n = 1'b1;
      claim = extra_claim && (i == 2);
      if (claim) kind = 3'd4;
      @(negedge clk);
    end
    claim = 1'b0; init_rdy_n = 1'b1; cyc_n = 1'b1;
    @(negedge clk);
    check(words == exp_words, req, "words moved", words, exp_words);
    check(dev_ack_n && term_n && data_rdy_n, req, "idle after end", int'(dev_ack_n), 1);
  endtask

  task automatic run_modem(input int sd, input int ra, input int gl,
                           input int exp_words, input string req);
    words = 0;
    @(negedge clk);
    claim = 1'b1; kind = 3'd4; cardbus = 1'b0; cyc_n = 1'b0; init_rdy_n = 1'b0;
    @(negedge clk);
    claim = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (i > 0 && dev_ack_n) break;
      mdm_sel_n = !(i >= sd && i != gl);
      mdm_rdy   = (ra > 0) && (i >= ra);
      if (!term_n) cyc_n = 1'b1;
      @(negedge clk);
    end
    mdm_sel_n = 1'b1; mdm_rdy = 1'b0; cyc_n = 1'b1; init_rdy_n = 1'b1;
    @(negedge clk);
    check(words == exp_words, req, "modem words moved", words, exp_words);
  endtask

  initial begin
    rst_n = 1'b0; claim = 1'b0; kind = 3'd0; cardbus = 1'b0;
    mdm_sel_n = 1'b1; mdm_rdy = 1'b0; cyc_n = 1'b1; init_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dev_ack_n && data_rdy_n && term_n, "R1", "reset pins", int'({dev_ack_n, data_rdy_n, term_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);

    run_access(3'd0, 1'b0, 0, 0, 1, "R2", 1'b0);   // config, single word
    run_access(3'd1, 1'b0, 3, 0, 1, "R5", 1'b0);   // registers, initiator wait states
    run_access(3'd2, 1'b0, 0, 3, 1, "R4", 1'b0);   // flash, initiator slow to see stop
    run_access(3'd3, 1'b1, 0, 0, 0, "R3", 1'b0);   // card info in CardBus mode: retry
    run_access(3'd3, 1'b0, 0, 0, 1, "R2", 1'b0);   // card info outside CardBus mode
    run_access(3'd6, 1'b0, 1, 1, 1, "R2", 1'b0);   // spare kind code
    run_access(3'd2, 1'b0, 0, 4, 1, "R11", 1'b1);  // second claim while busy
    run_access(3'd0, 1'b0, 2, 2, 1, "R6", 1'b0);   // stop and frame release together

    run_modem(2, 5, -1, 1, "R8");    // ready on the 4th chip-select edge
    run_modem(2, 8, -1, 1, "R8");    // ready on the 7th edge, same edge as expiry
    run_modem(2, 9, -1, 0, "R9");    // ready one edge too late
    run_modem(1, 0, -1, 0, "R9");    // never ready
    run_modem(2, 11, 5, 1, "R10");   // chip-select gap restarts the window
    run_modem(6, 9, -1, 1, "R10");   // long wait before chip-select

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule